// File: doc/BRIEF.md
# Register-Form Data-Processing Execution Unit

This block executes one 32-bit instruction word per cycle in which `instr_valid` is high. It covers only the register-operand data-processing group of a fixed 32-bit RISC encoding. The word is decoded into an operation and three 4-bit register indices. Two source registers are read from an internal file of sixteen 32-bit registers. Add, subtract, AND, XOR or OR is computed, and the result is written to the destination register at the clock edge. A word outside the supported subset raises `illegal` in the same cycle and changes nothing.

Software never reaches this block directly. A test environment presets registers through a load port, issues instruction words, and reads any register back through a combinational debug port. There are no condition flags, no immediate or shifted operands, no memory or branch handling, and no pipeline. Each instruction completes at the edge that accepts it.

Top module: `dpx_exec_unit`

## Requirements
- R1: The first source index is taken from word bits 19:16, the destination index from bits 15:12, and the second source index from bits 3:0. A legal word writes its result to the destination, and the new value is readable from the next cycle onward.
- R2: Opcode field bits 24:21 = 0100 writes first source + second source, wrapping modulo 2^32.
- R3: Opcode 0010 writes first source - second source, wrapping modulo 2^32.
- R4: Opcode 0000 writes the bitwise AND of the two sources, 0001 writes the bitwise XOR, and 1100 writes the bitwise OR.
- R5: A word is legal only when all of the following hold: bits 31:28 = 1110, bits 27:26 = 00, bit 25 = 0, and the opcode is one of the five values above. For any other word presented with `instr_valid` high, `illegal` is high in that same cycle and no register changes.
- R6: While `instr_valid` is low, `illegal` is low and the instruction word writes nothing.
- R7: Both sources are read before the write. When the destination equals a source, the old value is used.
- R8: Bit 20 and bits 11:4 of the word have no effect on legality or on the result.
- R9: While `rst_n` is low, all sixteen registers read zero. Reset takes effect at once, and its release takes effect two clock edges later.
- R10: `preload_en` writes `preload_data` into register `preload_idx` at the clock edge. If a legal instruction writes the same register in that cycle, the instruction result wins. If the two target different registers, both writes happen.
- R11: `dbg_data` shows register `dbg_idx` combinationally.
- R12: Word E0823003 writes r2+r3 to r3, word E0845002 writes r4+r2 to r5, and word E0423003 writes r2-r3 to r3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized on release |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| illegal | output | 1 | Presented word is outside the supported subset |
| preload_en | input | 1 | Load a register directly |
| preload_idx | input | 4 | Register index for the direct load |
| preload_data | input | 32 | Value for the direct load |
| dbg_idx | input | 4 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
The hardest case to reach from the ports is a cycle in which an instruction and a direct load land on the same register. Random stimulus rarely lines up both indices, so a directed step forces this collision and also a case where the two target different registers. Random words are biased towards legal condition, category and opcode values, while the ignored bits stay fully random, so that legal and illegal words are well mixed. Destinations that equal one or both sources are forced in directed steps and also occur at random.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned NREGS   = 1 << IDX_W;

  localparam logic [3:0] COND_ALWAYS = 4'b1110;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_EOR = 4'b0001,
    OP_SUB = 4'b0010,
    OP_ADD = 4'b0100,
    OP_ORR = 4'b1100
  } dp_op_e;

  typedef struct packed {
    logic             legal;
    dp_op_e           op;
    logic [IDX_W-1:0] src_a;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src_b;
  } dp_dec_t;
endpackage

// File: rtl/dpx_rst_sync.sv
module dpx_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/dpx_decode.sv
module dpx_decode
  import dpx_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output dp_dec_t            dec
);
  // Condition, category and operand-kind bits must match exactly
  localparam logic [INSTR_W-1:0] FIXED_MASK = 32'hFE00_0000;
  localparam logic [INSTR_W-1:0] FIXED_VAL  = {COND_ALWAYS, 3'b000, 25'd0};

  logic fixed_ok;
  logic op_ok;

  always_comb begin
    fixed_ok = ((word & FIXED_MASK) == FIXED_VAL);
    unique case (word[24:21])
      OP_AND, OP_EOR, OP_SUB, OP_ADD, OP_ORR: op_ok = 1'b1;
      default:                                op_ok = 1'b0;
    endcase
    dec.op    = dp_op_e'(word[24:21]);
    dec.src_a = word[19:16];
    dec.dst   = word[15:12];
    dec.src_b = word[3:0];
    dec.legal = fixed_ok && op_ok;
  end
endmodule

// File: rtl/dpx_alu.sv
module dpx_alu
  import dpx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  dp_op_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_EOR:  y = a ^ b;
      OP_ORR:  y = a | b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/dpx_regfile.sv
module dpx_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         ld_en,
  input  logic [AW-1:0]                ld_idx,
  input  logic [DATA_W-1:0]            ld_data,
  input  logic [AW-1:0]                rd_a_idx,
  input  logic [AW-1:0]                rd_b_idx,
  input  logic [AW-1:0]                dbg_idx,
  output logic [DATA_W-1:0]            rd_a,
  output logic [DATA_W-1:0]            rd_b,
  output logic [DATA_W-1:0]            dbg_data,
  output logic [DEPTH-1:0][DATA_W-1:0] all_q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic              hit_wr;
    logic              hit_ld;
    logic              en;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q_r;

    // Instruction write takes priority over a direct load to the same entry
    always_comb begin
      hit_wr = wr_en && (wr_idx == AW'(g));
      hit_ld = ld_en && (ld_idx == AW'(g));
      en     = hit_wr || hit_ld;
      d      = hit_wr ? wr_data : ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_r <= '0;
      else if (en) q_r <= d;
    end

    assign all_q[g] = q_r;
  end

  assign rd_a     = all_q[rd_a_idx];
  assign rd_b     = all_q[rd_b_idx];
  assign dbg_data = all_q[dbg_idx];
endmodule

// File: rtl/dpx_exec_unit.sv
module dpx_exec_unit
  import dpx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr_word,
  output logic               illegal,
  input  logic               preload_en,
  input  logic [IDX_W-1:0]   preload_idx,
  input  logic [DATA_W-1:0]  preload_data,
  input  logic [IDX_W-1:0]   dbg_idx,
  output logic [DATA_W-1:0]  dbg_data
);
  logic                        rst_sync_n;
  dp_dec_t                     dec;
  logic [DATA_W-1:0]           opnd_a;
  logic [DATA_W-1:0]           opnd_b;
  logic [DATA_W-1:0]           result;
  logic                        exec_wr;
  logic [NREGS-1:0][DATA_W-1:0] rf_q;

  dpx_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  dpx_decode u_dec (
    .word (instr_word),
    .dec  (dec)
  );

  dpx_regfile #(.DATA_W(DATA_W), .DEPTH(NREGS)) u_rf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (exec_wr),
    .wr_idx   (dec.dst),
    .wr_data  (result),
    .ld_en    (preload_en),
    .ld_idx   (preload_idx),
    .ld_data  (preload_data),
    .rd_a_idx (dec.src_a),
    .rd_b_idx (dec.src_b),
    .dbg_idx  (dbg_idx),
    .rd_a     (opnd_a),
    .rd_b     (opnd_b),
    .dbg_data (dbg_data),
    .all_q    (rf_q)
  );

  dpx_alu #(.DATA_W(DATA_W)) u_alu (
    .op (dec.op),
    .a  (opnd_a),
    .b  (opnd_b),
    .y  (result)
  );

  always_comb begin
    exec_wr = instr_valid && dec.legal;
    illegal = instr_valid && !dec.legal;
  end
endmodule

// File: rtl/dpx_exec_checker.sv
module dpx_exec_checker
  import dpx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                         clk,
  input logic                         rst_sync_n,
  input logic                         instr_valid,
  input logic [INSTR_W-1:0]           instr_word,
  input logic                         illegal,
  input logic                         preload_en,
  input logic [IDX_W-1:0]             preload_idx,
  input logic [DATA_W-1:0]            preload_data,
  input logic [NREGS-1:0][DATA_W-1:0] rf_q
);
  function automatic logic [DATA_W-1:0] expect_val(
    input logic [3:0] opc, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    case (opc)
      4'b0100: expect_val = a + b;
      4'b0010: expect_val = a - b;
      4'b0000: expect_val = a & b;
      4'b0001: expect_val = a ^ b;
      default: expect_val = a | b;
    endcase
  endfunction

  logic accepted;
  assign accepted = instr_valid && !illegal;

  // R5: a condition other than always is rejected
  assert_cond_reject_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && instr_word[31:28] != 4'b1110) |-> illegal);

  // R5: a set operand-kind bit or a nonzero category is rejected
  assert_category_reject_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && instr_word[27:25] != 3'b000) |-> illegal);

  // R6: no illegal indication without a valid word
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !instr_valid |-> !illegal);

  // R1: the destination holds the operation on the old sources
  assert_dest_result_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accepted |=> rf_q[$past(instr_word[15:12])] ==
      $past(expect_val(instr_word[24:21], rf_q[instr_word[19:16]], rf_q[instr_word[3:0]])));

  // R10: a direct load lands unless an instruction targets the same entry
  assert_preload_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (preload_en && !(accepted && instr_word[15:12] == preload_idx))
      |=> rf_q[$past(preload_idx)] == $past(preload_data));

  for (genvar g = 0; g < NREGS; g++) begin : g_hold
    // R5: entries not targeted by any write stay unchanged
    assert_reg_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!(accepted && instr_word[15:12] == 4'(g)) && !(preload_en && preload_idx == 4'(g)))
        |=> $stable(rf_q[g]));
  end
endmodule

bind dpx_exec_unit dpx_exec_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .instr_valid  (instr_valid),
  .instr_word   (instr_word),
  .illegal      (illegal),
  .preload_en   (preload_en),
  .preload_idx  (preload_idx),
  .preload_data (preload_data),
  .rf_q         (rf_q)
);

// File: tb/tb_dpx_exec_unit.sv
`timescale 1ns/100ps
module tb_dpx_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr_word;
  logic        illegal;
  logic        preload_en;
  logic [3:0]  preload_idx;
  logic [31:0] preload_data;
  logic [3:0]  dbg_idx;
  logic [31:0] dbg_data;

  logic [31:0] model [16];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dpx_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .illegal(illegal), .preload_en(preload_en), .preload_idx(preload_idx),
    .preload_data(preload_data), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  // Bench view of the encoding: {legal, result}
  function automatic logic [32:0] ref_exec(input logic [31:0] w, input logic [31:0] a,
                                           input logic [31:0] b);
    logic ok;
    logic [31:0] r;
    ok = (w[31:28] == 4'hE) && (w[27:25] == 3'b000);
    r  = '0;
    case (w[24:21])
      4'b0100: r = a + b;
      4'b0010: r = a - b;
      4'b0000: r = a & b;
      4'b0001: r = a ^ b;
      4'b1100: r = a | b;
      default: ok = 1'b0;
    endcase
    return {ok, r};
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] rn,
                                     input logic [3:0] rd, input logic [3:0] rm);
    return {4'hE, 3'b000, op, 1'b0, rn, rd, 8'h00, rm};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_reg(input logic [3:0] idx, input string tag);
    dbg_idx = idx;
    #0.1;
    check(tag, dbg_data, model[idx], $sformatf("r%0d", idx));
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 16; i++) check_reg(4'(i), tag);
  endtask

  task automatic run(input string tag, input logic v, input logic [31:0] w,
                     input logic pe, input logic [3:0] pi, input logic [31:0] pd);
    logic [32:0] r;
    @(negedge clk);
    instr_valid = v; instr_word = w;
    preload_en = pe; preload_idx = pi; preload_data = pd;
    r = ref_exec(w, model[w[19:16]], model[w[3:0]]);
    #1;
    check(tag, {31'd0, illegal}, {31'd0, v && !r[32]}, "illegal");
    @(posedge clk);
    #1;
    if (pe) model[pi] = pd;
    if (v && r[32]) model[w[15:12]] = r[31:0];
    instr_valid = 1'b0; preload_en = 1'b0;
    if (v && r[32]) check_reg(w[15:12], tag);
  endtask

  task automatic load(input logic [3:0] idx, input logic [31:0] val);
    run("R10", 1'b0, 32'h0, 1'b1, idx, val);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] legal_ops [5];
    legal_ops = '{4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1100};
    void'($urandom(32'd20240611));
    rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0;
    preload_en = 1'b0; preload_idx = '0; preload_data = '0; dbg_idx = '0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    sweep("R9");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R12 example words
    load(4'd2, 32'h0000_0010); load(4'd3, 32'h0000_0020);
    run("R12", 1'b1, 32'hE082_3003, 1'b0, 4'd0, 32'd0);
    check("R12", model[3], 32'h0000_0030, "r3 after first add word");
    load(4'd4, 32'h1234_0000); load(4'd2, 32'h0000_5678);
    run("R12", 1'b1, 32'hE084_5002, 1'b0, 4'd0, 32'd0);
    check("R12", model[5], 32'h1234_5678, "r5 after second add word");
    load(4'd3, 32'h0000_0008);
    run("R12", 1'b1, 32'hE042_3003, 1'b0, 4'd0, 32'd0);

    // R1 field placement with distinct indices
    load(4'd8, 32'd100); load(4'd9, 32'd3);
    run("R1", 1'b1, mk(4'b0010, 4'd8, 4'd10, 4'd9), 1'b0, 4'd0, 32'd0);
    check("R1", model[10], 32'd97, "r10 = r8 - r9");
    run("R1", 1'b1, mk(4'b0010, 4'd9, 4'd11, 4'd8), 1'b0, 4'd0, 32'd0);

    // R2 / R3 wrap
    load(4'd1, 32'hFFFF_FFFF); load(4'd0, 32'd2);
    run("R2", 1'b1, mk(4'b0100, 4'd1, 4'd6, 4'd0), 1'b0, 4'd0, 32'd0);
    check("R2", model[6], 32'd1, "wrapped sum");
    load(4'd12, 32'd0); load(4'd13, 32'd1);
    run("R3", 1'b1, mk(4'b0010, 4'd12, 4'd14, 4'd13), 1'b0, 4'd0, 32'd0);
    check("R3", model[14], 32'hFFFF_FFFF, "wrapped difference");

    // R4 bitwise group
    load(4'd1, 32'hF0F0_1234); load(4'd0, 32'hFF00_00FF);
    run("R4", 1'b1, mk(4'b0000, 4'd1, 4'd6, 4'd0), 1'b0, 4'd0, 32'd0);
    run("R4", 1'b1, mk(4'b0001, 4'd1, 4'd7, 4'd0), 1'b0, 4'd0, 32'd0);
    run("R4", 1'b1, mk(4'b1100, 4'd1, 4'd15, 4'd0), 1'b0, 4'd0, 32'd0);

    // R7 destination equals sources
    load(4'd7, 32'h4000_0003);
    run("R7", 1'b1, mk(4'b0100, 4'd7, 4'd7, 4'd7), 1'b0, 4'd0, 32'd0);
    check("R7", model[7], 32'h8000_0006, "doubled");
    run("R7", 1'b1, mk(4'b0010, 4'd7, 4'd7, 4'd1), 1'b0, 4'd0, 32'd0);

    // R8 ignored bits set
    run("R8", 1'b1, mk(4'b0100, 4'd1, 4'd2, 4'd0) | 32'h0010_0FF0, 1'b0, 4'd0, 32'd0);
    check("R8", model[2], 32'hF0F0_1234 + 32'hFF00_00FF, "sum with spare bits set");

    // R5 rejected words leave every register unchanged
    run("R5", 1'b1, mk(4'b0100, 4'd1, 4'd3, 4'd0) & 32'h0FFF_FFFF, 1'b0, 4'd0, 32'd0);
    run("R5", 1'b1, mk(4'b0100, 4'd1, 4'd3, 4'd0) | 32'h0200_0000, 1'b0, 4'd0, 32'd0);
    run("R5", 1'b1, mk(4'b0100, 4'd1, 4'd3, 4'd0) | 32'h0400_0000, 1'b0, 4'd0, 32'd0);
    run("R5", 1'b1, mk(4'b0011, 4'd1, 4'd3, 4'd0), 1'b0, 4'd0, 32'd0);
    sweep("R5");

    // R6 word without valid
    run("R6", 1'b0, mk(4'b0100, 4'd1, 4'd4, 4'd0), 1'b0, 4'd0, 32'd0);
    sweep("R6");

    // R10 collisions
    run("R10", 1'b1, mk(4'b0100, 4'd1, 4'd5, 4'd0), 1'b1, 4'd5, 32'hDEAD_BEEF);
    check("R10", model[5], 32'hF0F0_1234 + 32'hFF00_00FF, "instruction wins");
    run("R10", 1'b1, mk(4'b0001, 4'd1, 4'd8, 4'd0), 1'b1, 4'd9, 32'hCAFE_0001);
    check_reg(4'd9, "R10");

    // Random mix
    for (int n = 0; n < 800; n++) begin
      logic [31:0] w;
      logic        pe;
      w = $urandom;
      if ($urandom_range(0, 9) < 8) w[31:28] = 4'hE;
      if ($urandom_range(0, 9) < 8) w[27:25] = 3'b000;
      if ($urandom_range(0, 9) < 8) w[24:21] = legal_ops[$urandom_range(0, 4)];
      pe = ($urandom_range(0, 3) == 0);
      run("R1", ($urandom_range(0, 7) != 0), w, pe, 4'($urandom), $urandom);
      if (n % 100 == 99) sweep("R11");
    end

    // R9 asynchronous reset mid-run
    @(negedge clk); #0.5;
    rst_n = 1'b0;
    #0.5;
    for (int i = 0; i < 16; i++) model[i] = '0;
    sweep("R9");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    load(4'd1, 32'd5);
    run("R2", 1'b1, mk(4'b0100, 4'd1, 4'd2, 4'd1), 1'b0, 4'd0, 32'd0);
    check("R2", model[2], 32'd10, "sum after reset");
    sweep("R11");

    summary();
    $finish;
  end
endmodule